// File: doc/BRIEF.md
# Programmable Asynchronous Read Strobe Sequencer

This block runs one asynchronous read on a bus that carries the address and the data on the same wires. After a request is taken, a cycle counter starts at 0. The chip-select, address-valid and output-enable strobes are all active low. Each strobe is low from its own programmed start count up to, but not including, its own programmed stop count. The block drives the latched address onto the shared bus until the address-valid stop count, and then releases the bus so that the memory can drive data. It samples the bus at a programmed access count. After the programmed total length it returns the sampled word with a one-cycle done pulse.

All eight timing fields are sampled into a snapshot when a request is taken, so software may rewrite them while a read is in flight. A combinational check watches the live fields. If output-enable would start before address-valid has stopped, or if the total length does not cover every stop count and the access count, the block raises an error flag and refuses requests.

The state machine has three states:
- **IDLE**: every strobe is high and the block waits for a request.
- **ACTIVE**: the count runs from 0 to total-1.
- **DONE**: the one cycle that carries the response.

It has four transitions:
- IDLE→ACTIVE on an accepted request.
- ACTIVE→DONE when the count reaches total-1.
- DONE→ACTIVE on a request accepted in the done cycle.
- DONE→IDLE otherwise.

Top module: `async_rd_seq`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_adv_n` and `mem_oe_n` are 1, `bus_oe` is 0, `rsp_valid` is 0, and `req_ready` is 1 while the configuration is valid.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. Access count k=0 is the cycle that follows that edge, and count k is the k-th cycle after it.
- R3: `mem_cs_n` is 0 exactly when cs_on <= k < cs_off, where cs_on and cs_off are the values captured at acceptance.
- R4: `mem_adv_n` is 0 exactly when adv_on <= k < adv_off.
- R5: `mem_oe_n` is 0 exactly when oe_on <= k < oe_off.
- R6: `bus_oe` is 1 exactly when k < adv_off. While it is 1, `bus_out` equals the accepted address.
- R7: `rsp_data` equals the value that `bus_in` held during count k = access.
- R8: After counts 0 to total-1, the next cycle has `rsp_valid`=1 for one cycle, all strobes high, `bus_oe`=0 and `req_ready`=1. A request may be accepted in that cycle.
- R9: `cfg_err` is 1 when oe_on < adv_off.
- R10: `cfg_err` is 1 when total < cs_off, total < adv_off, total < oe_off, or total <= access.
- R11: While `cfg_err` is 1, `req_ready` is 0, requests start nothing, and all strobes stay high.
- R12: Changes to the timing inputs after acceptance have no effect on the read in flight.
- R13: During counts 0 to total-1, `req_ready` is 0 and a held `req_valid` starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cs_on | input | TW | Chip-select start count |
| cfg_cs_off | input | TW | Chip-select stop count |
| cfg_adv_on | input | TW | Address-valid start count |
| cfg_adv_off | input | TW | Address-valid stop count |
| cfg_oe_on | input | TW | Output-enable start count |
| cfg_oe_off | input | TW | Output-enable stop count |
| cfg_access | input | TW | Count at which data is sampled |
| cfg_total | input | TW | Total length of the read in cycles |
| cfg_err | output | 1 | Live configuration is invalid |
| req_valid | input | 1 | Read request |
| req_addr | input | DW | Read address |
| req_ready | output | 1 | Request can be accepted |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_data | output | DW | Sampled read data |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_adv_n | output | 1 | Address-valid, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| bus_out | output | DW | Value driven onto the shared bus |
| bus_oe | output | 1 | Bus driver enable |
| bus_in | input | DW | Value read from the shared bus |

## Verification
The hardest case to reach from the ports is a change to the timing inputs in the middle of a read. It must leave the strobes, the bus release and the sample point exactly as they were captured. To reach it, the stimulus rewrites the timing inputs with fresh random values, some of them invalid, right after acceptance, and puts the original values back before the done cycle. The bus input is also given a different value on every cycle of the read, so a sample taken one cycle early or late shows up as wrong data. Random legal timings are mixed with directed edge cases: a one-cycle read, sampling at count 0 and at the last count, and strobes whose start equals their stop.

// File: rtl/async_rd_pkg.sv
package async_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DONE   = 2'd2
    } rd_state_e;

    localparam int unsigned SB_CS  = 0;
    localparam int unsigned SB_ADV = 1;
    localparam int unsigned SB_OE  = 2;
    localparam int unsigned NUM_SB = 3;

endpackage

// File: rtl/async_rd_cfg_check.sv
module async_rd_cfg_check #(
    parameter int unsigned TW = 5
) (
    input  logic [TW-1:0] cs_off,
    input  logic [TW-1:0] adv_off,
    input  logic [TW-1:0] oe_on,
    input  logic [TW-1:0] oe_off,
    input  logic [TW-1:0] access,
    input  logic [TW-1:0] total,
    output logic          err
);
    logic turn_bad;
    logic len_bad;

    always_comb begin
        // output-enable may not overlap address phase on the shared bus
        turn_bad = (oe_on < adv_off);
        // total length must cover every stop count and the sample point
        len_bad  = (total < cs_off) || (total < adv_off) ||
                   (total < oe_off) || (total <= access);
        err      = turn_bad || len_bad;
    end
endmodule

// File: rtl/async_rd_window.sv
module async_rd_window #(
    parameter int unsigned TW = 5
) (
    input  logic          en,
    input  logic [TW-1:0] cnt,
    input  logic [TW-1:0] start,
    input  logic [TW-1:0] stop,
    output logic          hit
);
    always_comb begin
        hit = en && (cnt >= start) && (cnt < stop);
    end
endmodule

// File: rtl/async_rd_timer.sv
module async_rd_timer #(
    parameter int unsigned TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [TW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + TW'(1);
        end
    end
endmodule

// File: rtl/async_rd_seq.sv
module async_rd_seq
    import async_rd_pkg::*;
#(
    parameter int unsigned TW = 5,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] cfg_cs_on,
    input  logic [TW-1:0] cfg_cs_off,
    input  logic [TW-1:0] cfg_adv_on,
    input  logic [TW-1:0] cfg_adv_off,
    input  logic [TW-1:0] cfg_oe_on,
    input  logic [TW-1:0] cfg_oe_off,
    input  logic [TW-1:0] cfg_access,
    input  logic [TW-1:0] cfg_total,
    output logic          cfg_err,
    input  logic          req_valid,
    input  logic [DW-1:0] req_addr,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          mem_cs_n,
    output logic          mem_adv_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    input  logic [DW-1:0] bus_in
);
    localparam logic [TW-1:0] ONE = TW'(1);

    rd_state_e     state_q;
    rd_state_e     state_d;
    logic [TW-1:0] cnt;
    logic          accept;
    logic          active;
    logic          last;

    // snapshot of the timing taken at acceptance
    logic [TW-1:0] on_q  [NUM_SB];
    logic [TW-1:0] off_q [NUM_SB];
    logic [TW-1:0] on_in [NUM_SB];
    logic [TW-1:0] off_in[NUM_SB];
    logic [TW-1:0] acc_q;
    logic [TW-1:0] tot_q;
    logic [DW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [NUM_SB-1:0] hit;

    always_comb begin
        on_in[SB_CS]   = cfg_cs_on;
        off_in[SB_CS]  = cfg_cs_off;
        on_in[SB_ADV]  = cfg_adv_on;
        off_in[SB_ADV] = cfg_adv_off;
        on_in[SB_OE]   = cfg_oe_on;
        off_in[SB_OE]  = cfg_oe_off;
    end

    async_rd_cfg_check #(.TW(TW)) u_check (
        .cs_off  (cfg_cs_off),
        .adv_off (cfg_adv_off),
        .oe_on   (cfg_oe_on),
        .oe_off  (cfg_oe_off),
        .access  (cfg_access),
        .total   (cfg_total),
        .err     (cfg_err)
    );

    async_rd_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (active),
        .cnt   (cnt)
    );

    always_comb begin
        active    = (state_q == ST_ACTIVE);
        last      = active && (cnt == tot_q - ONE);
        req_ready = ((state_q == ST_IDLE) || (state_q == ST_DONE)) && !cfg_err;
        accept    = req_valid && req_ready;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_ACTIVE;
            ST_ACTIVE: if (last)   state_d = ST_DONE;
            ST_DONE:   state_d = accept ? ST_ACTIVE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // snapshot registers
    genvar g;
    generate
        for (g = 0; g < NUM_SB; g++) begin : g_snap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    on_q[g]  <= '0;
                    off_q[g] <= '0;
                end else if (accept) begin
                    on_q[g]  <= on_in[g];
                    off_q[g] <= off_in[g];
                end
            end

            async_rd_window #(.TW(TW)) u_win (
                .en    (active),
                .cnt   (cnt),
                .start (on_q[g]),
                .stop  (off_q[g]),
                .hit   (hit[g])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tot_q  <= ONE;
            addr_q <= '0;
        end else if (accept) begin
            acc_q  <= cfg_access;
            tot_q  <= cfg_total;
            addr_q <= req_addr;
        end
    end

    // data sample at the programmed access count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (active && (cnt == acc_q)) begin
            data_q <= bus_in;
        end
    end

    // outputs
    always_comb begin
        mem_cs_n  = !hit[SB_CS];
        mem_adv_n = !hit[SB_ADV];
        mem_oe_n  = !hit[SB_OE];
        bus_oe    = active && (cnt < off_q[SB_ADV]);
        bus_out   = bus_oe ? addr_q : '0;
        rsp_valid = (state_q == ST_DONE);
        rsp_data  = data_q;
    end
endmodule

// File: rtl/async_rd_seq_chk.sv
module async_rd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic cfg_err,
    input logic mem_cs_n,
    input logic mem_adv_n,
    input logic mem_oe_n,
    input logic bus_oe,
    input logic active
);
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> active); // R2

    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !req_ready); // R11

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !req_ready); // R13

    AST_NO_OE_WITH_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_adv_n)); // R9

    AST_NO_DRIVE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> mem_oe_n); // R6

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (mem_cs_n && mem_adv_n && mem_oe_n && !bus_oe)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R8

    AST_DONE_FOLLOWS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(active)); // R8
endmodule

bind async_rd_seq async_rd_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .cfg_err   (cfg_err),
    .mem_cs_n  (mem_cs_n),
    .mem_adv_n (mem_adv_n),
    .mem_oe_n  (mem_oe_n),
    .bus_oe    (bus_oe),
    .active    (active)
);

// File: tb/async_rd_seq_tb.sv
module async_rd_seq_tb;
    localparam int TW = 5;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] cfg_cs_on, cfg_cs_off, cfg_adv_on, cfg_adv_off;
    logic [TW-1:0] cfg_oe_on, cfg_oe_off, cfg_access, cfg_total;
    logic          cfg_err;
    logic          req_valid = 1'b0;
    logic [DW-1:0] req_addr = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_data, bus_out, bus_in = '0;
    logic          mem_cs_n, mem_adv_n, mem_oe_n, bus_oe;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;

    always #4 clk = ~clk; // 125 MHz

    async_rd_seq #(.TW(TW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_cs_on(cfg_cs_on), .cfg_cs_off(cfg_cs_off),
        .cfg_adv_on(cfg_adv_on), .cfg_adv_off(cfg_adv_off),
        .cfg_oe_on(cfg_oe_on), .cfg_oe_off(cfg_oe_off),
        .cfg_access(cfg_access), .cfg_total(cfg_total),
        .cfg_err(cfg_err),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit in_win(int k, int on, int off);
        return (k >= on) && (k < off);
    endfunction

    function automatic bit cfg_bad(int ao, int oo, int co, int of, int ac, int tt);
        return (oo < ao) || (tt < co) || (tt < ao) || (tt < of) || (tt <= ac);
    endfunction

    task automatic set_cfg(int cson, int csof, int avon, int avof,
                           int oeon, int oeof, int acc, int tot);
        cfg_cs_on = TW'(cson);  cfg_cs_off = TW'(csof);
        cfg_adv_on = TW'(avon); cfg_adv_off = TW'(avof);
        cfg_oe_on = TW'(oeon);  cfg_oe_off = TW'(oeof);
        cfg_access = TW'(acc);  cfg_total = TW'(tot);
    endtask

    task automatic scramble_cfg();
        set_cfg($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31),
                $urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31),
                $urandom_range(0, 31), $urandom_range(0, 31));
    endtask

    // one full read; called at a negedge, returns at the negedge of the done cycle
    task automatic do_read(int cson, int csof, int avon, int avof, int oeon,
                           int oeof, int acc, int tot, logic [DW-1:0] addr,
                           logic [DW-1:0] base, bit mess, bit hold);
        logic [DW-1:0] exp_data;
        set_cfg(cson, csof, avon, avof, oeon, oeof, acc, tot);
        req_addr  = addr;
        req_valid = 1'b1;
        #1;
        chk(cfg_err == 1'b0, "R10 valid cfg no error", 32'(cfg_err), 0);
        chk(req_ready == 1'b1, "R2 ready before accept", 32'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
        exp_data = base ^ DW'(acc);
        for (int k = 0; k < tot; k++) begin
            if (k == 0) begin
                if (mess) scramble_cfg();
                req_addr = ~addr;
            end
            bus_in = base ^ DW'(k);
            #1;
            chk(mem_cs_n == !in_win(k, cson, csof), "R3 cs window", 32'(mem_cs_n), 32'(!in_win(k, cson, csof)));
            chk(mem_adv_n == !in_win(k, avon, avof), "R4 adv window", 32'(mem_adv_n), 32'(!in_win(k, avon, avof)));
            chk(mem_oe_n == !in_win(k, oeon, oeof), "R5 oe window", 32'(mem_oe_n), 32'(!in_win(k, oeon, oeof)));
            chk(bus_oe == (k < avof), "R6 bus drive", 32'(bus_oe), 32'(k < avof));
            if (k < avof)
                chk(bus_out == addr, "R6 address on bus", 32'(bus_out), 32'(addr));
            chk(req_ready == 1'b0, "R13 busy not ready", 32'(req_ready), 0);
            chk(rsp_valid == 1'b0, "R8 no early done", 32'(rsp_valid), 0);
            if (mess && k == 0)
                chk(1'b1, "R12 cfg rewritten mid-read", 0, 0);
            if (k == tot - 1) begin
                set_cfg(cson, csof, avon, avof, oeon, oeof, acc, tot);
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        bus_in = ~base;
        #1;
        chk(rsp_valid == 1'b1, "R8 done pulse", 32'(rsp_valid), 1);
        chk(rsp_data == exp_data, "R7 sampled data", 32'(rsp_data), 32'(exp_data));
        chk(mem_cs_n && mem_adv_n && mem_oe_n && !bus_oe, "R8 strobes idle in done",
            {28'd0, mem_cs_n, mem_adv_n, mem_oe_n, bus_oe}, 32'hE);
        chk(req_ready == 1'b1, "R8 ready in done", 32'(req_ready), 1);
    endtask

    task automatic rand_read(bit mess);
        int tot = $urandom_range(2, 20);
        int acc = $urandom_range(0, tot - 1);
        int avof = $urandom_range(0, tot);
        do_read($urandom_range(0, tot), $urandom_range(0, tot), $urandom_range(0, tot),
                avof, $urandom_range(avof, 31), $urandom_range(0, tot), acc, tot,
                DW'($urandom), DW'($urandom), mess, $urandom_range(0, 1) == 1);
    endtask

    task automatic bad_cfg(int cson, int csof, int avon, int avof, int oeon,
                           int oeof, int acc, int tot, string req);
        set_cfg(cson, csof, avon, avof, oeon, oeof, acc, tot);
        req_valid = 1'b1;
        #1;
        chk(cfg_err == cfg_bad(avof, oeon, csof, oeof, acc, tot), req, 32'(cfg_err), 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #1;
            chk(req_ready == 1'b0, "R11 not ready on error", 32'(req_ready), 0);
            chk(mem_cs_n && mem_adv_n && mem_oe_n && !rsp_valid, "R11 nothing starts",
                {29'd0, mem_cs_n, mem_adv_n, mem_oe_n}, 32'h7);
        end
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 150000) begin
                n_fail++;
                n_chk++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc_cnt);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'd2024));
        set_cfg(0, 10, 1, 2, 3, 10, 9, 11);
        repeat (3) @(negedge clk);
        #1;
        chk(mem_cs_n && mem_adv_n && mem_oe_n && !bus_oe, "R1 strobes after reset",
            {28'd0, mem_cs_n, mem_adv_n, mem_oe_n, bus_oe}, 32'hE);
        chk(rsp_valid == 1'b0, "R1 no response in reset", 32'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
        chk(mem_cs_n && mem_adv_n && mem_oe_n && !bus_oe, "R1 idle strobes",
            {28'd0, mem_cs_n, mem_adv_n, mem_oe_n, bus_oe}, 32'hE);
        @(negedge clk);
        // directed timings
        do_read(0, 10, 1, 1, 3, 10, 9, 11, 16'hA5C3, 16'h1200, 1'b0, 1'b0);
        do_read(0, 10, 0, 2, 3, 10, 9, 11, 16'h0F0F, 16'h3400, 1'b0, 1'b1);
        do_read(0, 1, 0, 1, 1, 1, 0, 1, 16'h8001, 16'h5600, 1'b0, 1'b0); // one-cycle read
        do_read(2, 6, 1, 3, 3, 6, 5, 6, 16'h7777, 16'h7800, 1'b1, 1'b0); // sample at last count
        do_read(0, 4, 0, 0, 0, 4, 0, 4, 16'h1357, 16'h9A00, 1'b1, 1'b1); // sample at 0, no adv
        do_read(31, 20, 5, 5, 31, 20, 19, 20, 16'hBEEF, 16'hBC00, 1'b0, 1'b0);
        @(negedge clk);
        // invalid configurations
        bad_cfg(0, 10, 1, 4, 3, 10, 9, 11, "R9 oe before adv stop");
        bad_cfg(0, 12, 0, 1, 3, 10, 9, 11, "R10 cs stop past total");
        bad_cfg(0, 10, 0, 1, 3, 10, 11, 11, "R10 access equals total");
        bad_cfg(0, 10, 0, 1, 3, 14, 9, 11, "R10 oe stop past total");
        bad_cfg(0, 0, 0, 0, 0, 0, 0, 0, "R10 zero total");
        @(negedge clk);
        // random legal timings, some rewritten in flight
        for (int t = 0; t < 200; t++) begin
            rand_read($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        for (int t = 0; t < 40; t++) begin
            int tot = $urandom_range(1, 20);
            int avof = $urandom_range(1, tot);
            bad_cfg(0, tot, 0, avof, avof - 1, tot, 0, tot, "R9 random turnaround");
        end
        set_cfg(0, 10, 0, 2, 3, 10, 9, 11);
        @(negedge clk);
        #1;
        chk(mem_cs_n && !rsp_valid, "R13 no extra read after held request",
            {30'd0, mem_cs_n, rsp_valid}, 32'h2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule